// File: doc/BRIEF.md
# DMA Page and Address Composer

This block keeps an 8-bit page register for each of eight DMA channels and uses it to widen a channel's 16-bit current address into a 24-bit system address. Channels 0 to 3 move bytes. For them the page supplies address bits 23:16 and the channel address supplies bits 15:0. Channels 4 to 7 move 16-bit words. For them the channel address counts words, so it is shifted left by one. The page then supplies only bits 23:17, and its bit 0 is ignored. A byte channel therefore sees a 64 KB window, and a word channel a 128 KB window.

Software programs the pages through a small I/O port with 4-bit offsets. The pages read back at the offsets they were written to. A separate combinational check takes a channel, a 24-bit start address and a length, and reports whether that transfer is legal for the channel's class.

Top module: `dma_page_composer`

## Requirements
- R1: After reset every page register holds 0x00.
- R2: A write (io_wr high at a rising clock edge) stores io_wdata into the page of the channel its offset selects. Offsets 0x7, 0x3, 0x1, 0x2 select channels 0, 1, 2, 3. Offsets 0xF, 0xB, 0x9, 0xA select channels 4, 5, 6, 7.
- R3: io_rdata combinationally returns the page at the offset on io_addr. An offset that selects no channel reads as 0x00.
- R4: A write to an offset that selects no channel changes no page register. Without a write, every page register holds its value.
- R5: For a byte channel (ch_sel bit 2 = 0), sys_addr = {page, ch_addr}.
- R6: For a word channel (ch_sel bit 2 = 1), sys_addr = {page[7:1], ch_addr, 0}. Page bit 0 has no effect on the address.
- R7: chk_ok is low when chk_len exceeds 65536 on a byte channel or 131072 on a word channel.
- R8: On a word channel (chk_chan bit 2 = 1), chk_ok is low when chk_len or chk_start is odd.
- R9: chk_ok is low when the last byte (chk_start + chk_len - 1) lies in a different window than chk_start. The window is 64 KB (bits 23:16 and above) on byte channels and 128 KB (bits 23:17 and above) on word channels. This includes a transfer that runs past the top of the 24-bit space. A zero length never crosses a window. A request that breaks none of R7 to R9 is legal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Page write strobe |
| io_addr | input | 4 | Page port offset |
| io_wdata | input | 8 | Page write data |
| io_rdata | output | 8 | Page read data at io_addr |
| ch_sel | input | 3 | Channel whose address is composed |
| ch_addr | input | 16 | Channel current address |
| sys_addr | output | 24 | Composed system address |
| chk_chan | input | 3 | Channel of the request under check |
| chk_start | input | 24 | Start byte address of the request |
| chk_len | input | 18 | Request length in bytes |
| chk_ok | output | 1 | Request is legal |

## Verification
The assertions assume that io_wr and io_addr are stable around the clock edge. They also assume that the check inputs are steady at the time chk_ok is read. The bench meets this by driving every input on the falling edge and sampling on the next half cycle. Random lengths are drawn across the whole 18-bit range, and random starts across the whole 24-bit range. Directed cases sit at the exact size limits, at odd word alignments, at window edges and at the top of the address space.

// File: rtl/dma_page_composer.sv
module dma_page_composer #(
  parameter int NCH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic [3:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  input  logic [2:0]  ch_sel,
  input  logic [15:0] ch_addr,
  output logic [23:0] sys_addr,
  input  logic [2:0]  chk_chan,
  input  logic [23:0] chk_start,
  input  logic [17:0] chk_len,
  output logic        chk_ok
);
  localparam logic [17:0] BYTE_MAX = 18'd65536;
  localparam logic [17:0] WORD_MAX = 18'd131072;

  logic [7:0]      page_q [NCH];
  logic [8*NCH-1:0] pages_flat;

  function automatic logic [3:0] decode(input logic [3:0] off);
    case (off)
      4'h7: decode = 4'b1000;
      4'h3: decode = 4'b1001;
      4'h1: decode = 4'b1010;
      4'h2: decode = 4'b1011;
      4'hF: decode = 4'b1100;
      4'hB: decode = 4'b1101;
      4'h9: decode = 4'b1110;
      4'hA: decode = 4'b1111;
      default: decode = 4'b0000;
    endcase
  endfunction

  logic [3:0] wr_dec, rd_dec;
  logic       wr_hit;
  logic [2:0] wr_ch;
  assign wr_dec = decode(io_addr);
  assign rd_dec = wr_dec;
  assign wr_hit = wr_dec[3];
  assign wr_ch  = wr_dec[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) page_q[i] <= '0;
    end else if (io_wr && wr_hit) begin
      page_q[wr_ch] <= io_wdata;
    end
  end

  always_comb
    for (int i = 0; i < NCH; i++) pages_flat[8*i +: 8] = page_q[i];

  assign io_rdata = rd_dec[3] ? page_q[rd_dec[2:0]] : 8'h00;

  logic [7:0] sel_page;
  assign sel_page = page_q[ch_sel];
  assign sys_addr = ch_sel[2] ? {sel_page[7:1], ch_addr, 1'b0}
                              : {sel_page, ch_addr};

  logic        wide;
  logic [24:0] last;
  logic        too_long, misaligned, crosses;
  assign wide       = chk_chan[2];
  assign last       = {1'b0, chk_start} + {7'd0, chk_len} - 25'd1;
  assign too_long   = chk_len > (wide ? WORD_MAX : BYTE_MAX);
  assign misaligned = wide && (chk_len[0] || chk_start[0]);
  assign crosses    = (chk_len != '0) &&
                      (wide ? ({1'b0, chk_start[23:17]} != last[24:17])
                            : ({1'b0, chk_start[23:16]} != last[24:16]));
  assign chk_ok     = !(too_long || misaligned || crosses);

  property p_write_lands;
    @(posedge clk) disable iff (!rst_n)
      (io_wr && wr_hit) |=> (page_q[$past(wr_ch)] == $past(io_wdata));
  endproperty
  assert_write_lands_R2: assert property (p_write_lands);

  property p_idle_hold;
    @(posedge clk) disable iff (!rst_n)
      !(io_wr && wr_hit) |=> $stable(pages_flat);
  endproperty
  assert_pages_hold_R4: assert property (p_idle_hold);

  property p_reset_zero;
    @(posedge clk) !rst_n |=> (pages_flat == '0);
  endproperty
  assert_reset_zero_R1: assert property (p_reset_zero);

  always_comb begin
    if (rst_n && chk_ok) begin
      assert_len_limit_R7: assert (chk_len <= (wide ? WORD_MAX : BYTE_MAX));
      if (wide) assert_word_even_R8: assert (!chk_len[0] && !chk_start[0]);
    end
    if (rst_n && ch_sel[2]) assert_word_lsb_R6: assert (sys_addr[0] == 1'b0);
  end
endmodule

// File: tb/test_dma_page_composer.sv
module test_dma_page_composer;
  logic        clk = 0, rst_n = 0, io_wr = 0;
  logic [3:0]  io_addr = 0;
  logic [7:0]  io_wdata = 0, io_rdata;
  logic [2:0]  ch_sel = 0, chk_chan = 0;
  logic [15:0] ch_addr = 0;
  logic [23:0] sys_addr, chk_start = 0;
  logic [17:0] chk_len = 0;
  logic        chk_ok;
  int checks = 0, errors = 0;
  logic [7:0] ref_page [8];

  dma_page_composer i_dma_page_composer (.*);

  always #10 clk = ~clk;

  function automatic int chan_of(input logic [3:0] off);
    int t [16] = '{-1, 2, 3, 1, -1, -1, -1, 0, -1, 6, 7, 5, -1, -1, -1, 4};
    return t[off];
  endfunction

  function automatic bit legal(input logic [2:0] c, input logic [23:0] s, input logic [17:0] l);
    longint last; int sh;
    bit w = c[2];
    if (l > (w ? 131072 : 65536)) return 0;
    if (w && (l[0] || s[0])) return 0;
    if (l == 0) return 1;
    last = longint'(s) + longint'(l) - 1;
    sh = w ? 17 : 16;
    return (longint'(s) >> sh) == (last >> sh);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pwrite(input logic [3:0] off, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = off; io_wdata = d;
    @(negedge clk); io_wr = 0;
    if (chan_of(off) >= 0) ref_page[chan_of(off)] = d;
  endtask

  task automatic read_all(input string req);
    for (int o = 0; o < 16; o++) begin
      io_addr = o[3:0]; #1;
      check(req, io_rdata, chan_of(o[3:0]) >= 0 ? ref_page[chan_of(o[3:0])] : 0);
    end
  endtask

  task automatic compose(input logic [2:0] c, input logic [15:0] a);
    logic [23:0] e;
    ch_sel = c; ch_addr = a; #1;
    e = c[2] ? {ref_page[c][7:1], a, 1'b0} : {ref_page[c], a};
    check(c[2] ? "R6" : "R5", sys_addr, e);
  endtask

  task automatic legality(input string req, input logic [2:0] c, input logic [23:0] s, input logic [17:0] l);
    chk_chan = c; chk_start = s; chk_len = l; #1;
    check(req, chk_ok, legal(c, s, l));
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 8; i++) ref_page[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    read_all("R1");
    pwrite(4'h7, 8'h11); pwrite(4'h3, 8'h22); pwrite(4'h1, 8'h33); pwrite(4'h2, 8'h44);
    pwrite(4'hF, 8'h55); pwrite(4'hB, 8'h66); pwrite(4'h9, 8'h77); pwrite(4'hA, 8'h88);
    read_all("R2");
    pwrite(4'h0, 8'hFF); pwrite(4'h4, 8'hEE); pwrite(4'hC, 8'hDD);
    read_all("R4");
    pwrite(4'hF, 8'hA5);
    compose(3'd4, 16'hFFFF);
    pwrite(4'hF, 8'hA4);
    compose(3'd4, 16'hFFFF);
    compose(3'd0, 16'h1234);
    for (int i = 0; i < 200; i++) begin
      pwrite(4'($urandom), 8'($urandom));
      read_all("R3");
      compose(3'($urandom), 16'($urandom));
    end
    legality("R7", 3'd1, 24'h010000, 18'd65536);
    legality("R7", 3'd1, 24'h010000, 18'd65537);
    legality("R7", 3'd5, 24'h020000, 18'd131072);
    legality("R7", 3'd5, 24'h020000, 18'd131074);
    legality("R8", 3'd6, 24'h000001, 18'd4);
    legality("R8", 3'd6, 24'h000002, 18'd3);
    legality("R9", 3'd2, 24'h01FFFF, 18'd1);
    legality("R9", 3'd2, 24'h01FFFF, 18'd2);
    legality("R9", 3'd7, 24'h01FFFE, 18'd4);
    legality("R9", 3'd3, 24'hFFFFFF, 18'd0);
    legality("R9", 3'd4, 24'hFFFFFE, 18'd4);
    for (int i = 0; i < 2000; i++)
      legality("R9", 3'($urandom), 24'($urandom), 18'($urandom));
    for (int i = 0; i < 500; i++)
      legality("R8", 3'($urandom) | 3'd4, 24'($urandom) & 24'hFE0000 | 24'($urandom % 8), 18'($urandom % 16));
    rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 8; i++) ref_page[i] = 0;
    read_all("R1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule